// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Latch Controller

This block sits behind a serial receiver and turns each completed 16-bit command word into register updates for two output channels. The receiver presents the whole word together with a one-cycle commit strobe. The top four bits are program bits and the low twelve bits are the channel code.

The block keeps three code registers: output latch A, output latch B, and a holding buffer that feeds latch B. Software can load the holding buffer on its own without touching either output. A later write to latch A then moves the new A code and the buffered B code in the same clock edge, so both channels change together. Two mode flags, a speed select and a power-down request, are taken from every committed word. A one-cycle pulse marks each cycle in which either latch output has just changed value.

Top module: `dual_latch_ctrl`

## Requirements
- R1: After reset, latch A, latch B, the holding buffer, both flags and the update pulse are all zero.
- R2: On a commit with bit 15 = 1, latch A takes the code in bits 11..0. Latch B takes the holding buffer's contents in the same edge. The holding buffer keeps its value.
- R3: On a commit with bit 15 = 0 and bit 12 = 0, latch B and the holding buffer both take the code, and latch A keeps its value.
- R4: On a commit with bit 15 = 0 and bit 12 = 1, only the holding buffer takes the code. Both latch outputs keep their values, and the buffered code reaches latch B only through a later R2 write.
- R5: On every commit, whatever the write type, fast_mode takes bit 14 (1 = fast, 0 = slow) and power_down takes bit 13 (1 = powered down).
- R6: In a cycle with commit low, no latch, buffer or flag changes, whatever is on the word input.
- R7: The update pulse is high during exactly those cycles that follow a commit edge in which latch A or latch B changed value. All updates appear in the cycle after the edge that sampled commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| commit | input | 1 | One-cycle strobe: the word is complete |
| word | input | 16 | Command word: program bits 15..12, code 11..0 |
| latch_a | output | 12 | Channel A output latch |
| latch_b | output | 12 | Channel B output latch |
| fast_mode | output | 1 | Speed select flag |
| power_down | output | 1 | Power-down flag |
| update_pulse | output | 1 | High for the cycle after any latch changed |

## Verification
A directed sequence first loads the holding buffer alone and then writes latch A. This separates a correct simultaneous two-channel update from a design that writes latch B at the buffer-only step or that never copies the buffer. Repeated latch A writes after a plain B write show that B stays put when the buffer already matches it, with no spurious pulse. Writing the same value twice tells a value-change pulse apart from a pulse on every commit. Random words, mixed with cycles where commit is low and the word toggles, compare all outputs against a bench model and expose wrong bit decoding, flags held on some write types, and updates without a strobe.

// File: rtl/dual_latch_ctrl.sv
module dual_latch_ctrl #(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [CODE_W+3:0] word,
  output logic [CODE_W-1:0] latch_a,
  output logic [CODE_W-1:0] latch_b,
  output logic              fast_mode,
  output logic              power_down,
  output logic              update_pulse
);
  localparam int WORD_W = CODE_W + 4;

  logic [CODE_W-1:0] hold_q;
  logic [CODE_W-1:0] next_a, next_b, next_hold;

  wire              sel_a    = word[WORD_W-1];
  wire              speed    = word[WORD_W-2];
  wire              pdn      = word[WORD_W-3];
  wire              buf_only = word[WORD_W-4];
  wire [CODE_W-1:0] code     = word[CODE_W-1:0];

  assign next_a    = (commit && sel_a) ? code : latch_a;
  assign next_hold = (commit && !sel_a) ? code : hold_q;

  always_comb begin
    next_b = latch_b;
    if (commit) begin
      if (sel_a)          next_b = hold_q;
      else if (!buf_only) next_b = code;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_a      <= '0;
      latch_b      <= '0;
      hold_q       <= '0;
      fast_mode    <= 1'b0;
      power_down   <= 1'b0;
      update_pulse <= 1'b0;
    end else begin
      latch_a      <= next_a;
      latch_b      <= next_b;
      hold_q       <= next_hold;
      update_pulse <= (next_a != latch_a) || (next_b != latch_b);
      if (commit) begin
        fast_mode  <= speed;
        power_down <= pdn;
      end
    end
  end
endmodule

// File: rtl/dual_latch_ctrl_chk.sv
module dual_latch_ctrl_chk #(
  parameter int CODE_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              commit,
  input logic [CODE_W+3:0] word,
  input logic [CODE_W-1:0] latch_a,
  input logic [CODE_W-1:0] latch_b,
  input logic              fast_mode,
  input logic              power_down,
  input logic              update_pulse
);
  localparam int WORD_W = CODE_W + 4;

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> ($stable(latch_a) && $stable(latch_b) && $stable(fast_mode) && $stable(power_down)));

  assert_a_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && word[WORD_W-1]) |=> (latch_a == $past(word[CODE_W-1:0])));

  assert_b_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !word[WORD_W-1] && !word[WORD_W-4]) |=> ($stable(latch_a) && latch_b == $past(word[CODE_W-1:0])));

  assert_buf_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && !word[WORD_W-1] && word[WORD_W-4]) |=> ($stable(latch_a) && $stable(latch_b)));

  assert_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (fast_mode == $past(word[WORD_W-2]) && power_down == $past(word[WORD_W-3])));

  assert_pulse_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    update_pulse |-> (!$stable(latch_a) || !$stable(latch_b)));

  assert_pulse_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !update_pulse |-> ($stable(latch_a) && $stable(latch_b)));
endmodule

bind dual_latch_ctrl dual_latch_ctrl_chk #(.CODE_W(CODE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
  .latch_a(latch_a), .latch_b(latch_b), .fast_mode(fast_mode),
  .power_down(power_down), .update_pulse(update_pulse)
);

// File: tb/dual_latch_ctrl_tb_top.sv
module dual_latch_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CODE_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              commit = 1'b0;
  logic [CODE_W+3:0] word = '0;
  logic [CODE_W-1:0] latch_a, latch_b;
  logic              fast_mode, power_down, update_pulse;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [CODE_W-1:0] m_a = '0, m_b = '0, m_buf = '0;
  logic              m_fast = 1'b0, m_pd = 1'b0, m_pulse = 1'b0;

  dual_latch_ctrl #(.CODE_W(CODE_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
    .latch_a(latch_a), .latch_b(latch_b), .fast_mode(fast_mode),
    .power_down(power_down), .update_pulse(update_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [CODE_W+3:0] mk(bit a, bit f, bit p, bit bo, logic [CODE_W-1:0] c);
    return {a, f, p, bo, c};
  endfunction

  function automatic string req_of(bit c, logic [CODE_W+3:0] w);
    if (!c) return "R6";
    if (w[15]) return "R2";
    if (!w[12]) return "R3";
    return "R4";
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model(bit c, logic [CODE_W+3:0] w);
    logic [CODE_W-1:0] na, nb, nbuf;
    na = m_a; nb = m_b; nbuf = m_buf;
    if (c) begin
      if (w[15]) begin na = w[11:0]; nb = m_buf; end
      else if (!w[12]) begin nb = w[11:0]; nbuf = w[11:0]; end
      else nbuf = w[11:0];
      m_fast = w[14];
      m_pd = w[13];
    end
    m_pulse = (na != m_a) || (nb != m_b);
    m_a = na; m_b = nb; m_buf = nbuf;
  endtask

  task automatic step(bit c, logic [CODE_W+3:0] w);
    string r;
    commit = c;
    word = w;
    @(posedge clk);
    @(negedge clk);
    model(c, w);
    r = req_of(c, w);
    check(r, "latch_a", int'(latch_a), int'(m_a));
    check(r, "latch_b", int'(latch_b), int'(m_b));
    check(c ? "R5" : "R6", "fast_mode", int'(fast_mode), int'(m_fast));
    check(c ? "R5" : "R6", "power_down", int'(power_down), int'(m_pd));
    check("R7", "update_pulse", int'(update_pulse), int'(m_pulse));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    repeat (3) @(negedge clk);
    check("R1", "latch_a", int'(latch_a), 0);
    check("R1", "latch_b", int'(latch_b), 0);
    check("R1", "fast_mode", int'(fast_mode), 0);
    check("R1", "power_down", int'(power_down), 0);
    check("R1", "update_pulse", int'(update_pulse), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: buffer reset to zero, so an A write leaves B at zero
    step(1, mk(1, 0, 0, 0, 12'h123));
    // R4: buffer-only write, outputs hold, flags still taken (R5)
    step(1, mk(0, 1, 1, 1, 12'hABC));
    // R2: simultaneous update, B receives buffered code
    step(1, mk(1, 0, 0, 0, 12'hFFF));
    // R2: A write again, B equals buffer, B unchanged
    step(1, mk(1, 1, 0, 1, 12'hFFF));
    // R7: same values, no pulse
    step(1, mk(1, 1, 0, 0, 12'hFFF));
    // R3: B and buffer written
    step(1, mk(0, 0, 1, 0, 12'h000));
    step(1, mk(1, 0, 0, 0, 12'h555));
    // R6: no commit, word toggles
    step(0, mk(1, 1, 1, 0, 12'h0F0));
    step(0, mk(0, 0, 0, 0, 12'hF0F));

    for (int i = 0; i < 400; i++) begin
      bit c;
      logic [CODE_W+3:0] w;
      c = ($urandom % 4) != 0;
      w = 16'($urandom);
      step(c, w);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule